// File: doc/BRIEF.md
# Phase-Accumulator PWM Carrier Generator

This block produces one raw pulse-width modulated bit. The carrier comes from a 32-bit fractional phase accumulator. Every clock the accumulator adds a frequency word, which is the share of one carrier period covered by a single clock cycle. The accumulator wraps at one full period. The carrier is either the accumulator value itself, which gives a sawtooth, or the accumulator folded about its midpoint, which gives a triangle. In triangle mode the active phase is centred on the period start. The output is active while the carrier lies below the latched duty word.

A sync pulse reloads the phase with a programmable initial value, given in thousandths of a period. Without sync pulses the carrier runs freely. The duty word is latched at each period start. In triangle mode an optional setting also latches it when the carrier passes mid-period. Two one-cycle strobes mark the period start and the mid-period crossing for downstream logic, such as a dead-time or complementary-output stage. A polarity input chooses whether the output is active-high or active-low.

Top module: `pwm_carrier_gen`

## Requirements
- R1: Each clock the phase advances by `freq` modulo 2^32. When the addition overflows, `periodStrobe` is high for exactly the following cycle.
- R2: When the phase moves from below 2^31 to 2^31 or above without a sync, `midStrobe` is high for exactly the following cycle. The two strobes are never high together.
- R3: A sync pulse loads the phase with `initPhase` × 4294967. `initPhase` values above 999 saturate to 999. A sync also counts as a period start: in the following cycle `periodStrobe` is high and `midStrobe` is low.
- R4: With the latched mode 0 (sawtooth), the output is active while phase < duty × 2^22.
- R5: With the latched mode 1 (triangle), the carrier is the phase shifted left by one bit, with its lower 31 bits inverted first when the phase is 2^31 or above. The output is active while this carrier < duty × 2^22.
- R6: `symMode` is sampled only at a period start (a wrap or a sync). Changes between period starts do not affect the carrier shape.
- R7: `duty` is an unsigned fixed-point value with 1 integer bit and 10 fraction bits (1024 means 1.0). It is latched at each period start, and changes between latch points have no effect on the output.
- R8: When the latched mode is 1 and `midUpdate` is 1, `duty` is also latched at the mid-period crossing. In mode 0, or when `midUpdate` is 0, the crossing does not latch it.
- R9: A latched duty of 0 gives a constant inactive output. A latched duty of 1024 or more gives a constant active output, with no pulse at period boundaries.
- R10: With `activeHigh` = 1 the active state drives `pwmOut` to 1. With `activeHigh` = 0 the active state drives it to 0.
- R11: Reset clears the phase, the latched duty and the latched mode, and both strobes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Reloads the initial phase and starts a new period |
| freq | input | 32 | Phase increment per clock, as a fraction of a period |
| initPhase | input | 10 | Initial phase in thousandths of a period |
| duty | input | 11 | Duty value, 1.10 unsigned fixed point |
| symMode | input | 1 | Carrier shape: 0 sawtooth, 1 triangle |
| midUpdate | input | 1 | Also latch the duty at mid-period when in triangle mode |
| activeHigh | input | 1 | Output sense: 1 active-high, 0 active-low |
| pwmOut | output | 1 | Raw PWM bit |
| periodStrobe | output | 1 | One-cycle pulse after a period start |
| midStrobe | output | 1 | One-cycle pulse after the mid-period crossing |

## Verification
The hardest case to reach is a duty change that lands between a period start and the mid-period crossing while the block is in triangle mode. In that case the mid-period latch alone decides whether the new value takes effect. To reach it, the stimulus uses a frequency of 2^26, which makes a 64-cycle period. The sync pulses are placed so the bench knows the phase exactly. The bench then changes `duty` a fixed number of cycles into the period with `midUpdate` set and then cleared. It also flips `symMode` inside a period to show the shape holds until the next wrap. A cycle-accurate model, built from the requirements, predicts every output bit.

// File: rtl/pwm_carrier_pkg.sv
package pwm_carrier_pkg;
  // events computed from the pre-edge phase, consumed at the same edge
  typedef struct packed {
    logic periodLoad;  // wrap or sync: new period begins
    logic midCross;    // phase passes one half (no sync)
  } carrier_evt_t;
endpackage

// File: rtl/pwm_carrier_ctrl.sv
module pwm_carrier_ctrl
  import pwm_carrier_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int PH_W     = 10,
  parameter int PH_STEPS = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic [ACC_W-1:0] freq,
  input  logic [PH_W-1:0]  initPhase,
  output carrier_evt_t     evt,
  output logic [ACC_W-1:0] phase,
  output logic             periodStrobe,
  output logic             midStrobe
);
  localparam longint unsigned PH_UNIT = ((64'd1 << ACC_W) + PH_STEPS / 2) / PH_STEPS;
  localparam logic [PH_W-1:0] PH_MAX  = PH_W'(PH_STEPS - 1);

  logic [ACC_W:0]   sumW;
  logic             carry;
  logic             halfCross;
  logic [PH_W-1:0]  phSat;
  logic [63:0]      phProd;
  logic [ACC_W-1:0] loadVal;

  always_comb begin
    sumW      = {1'b0, phase} + {1'b0, freq};
    carry     = sumW[ACC_W];
    halfCross = !phase[ACC_W-1] && sumW[ACC_W-1];
    phSat     = (initPhase > PH_MAX) ? PH_MAX : initPhase;
    phProd    = 64'(phSat) * PH_UNIT;
    loadVal   = phProd[ACC_W-1:0];
    evt.periodLoad = sync || carry;
    evt.midCross   = !sync && halfCross;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= '0;
      periodStrobe <= 1'b0;
      midStrobe    <= 1'b0;
    end else begin
      phase        <= sync ? loadVal : sumW[ACC_W-1:0];
      periodStrobe <= evt.periodLoad;
      midStrobe    <= evt.midCross;
    end
  end

  // R1
  wrap_residue_chk: assert property (@(posedge clk) disable iff (rst)
    (periodStrobe && !$past(sync)) |-> (phase < $past(freq)));
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(periodStrobe && midStrobe));
  // R3
  sync_start_chk: assert property (@(posedge clk) disable iff (rst)
    sync |=> (periodStrobe && !midStrobe));
endmodule

// File: rtl/pwm_carrier_dp.sv
module pwm_carrier_dp
  import pwm_carrier_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int DUTY_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  carrier_evt_t      evt,
  input  logic [ACC_W-1:0]  phase,
  input  logic [DUTY_W-1:0] duty,
  input  logic              symMode,
  input  logic              midUpdate,
  input  logic              activeHigh,
  output logic              pwmOut
);
  localparam int SHIFT = ACC_W - (DUTY_W - 1);

  logic [DUTY_W-1:0] dutyQ;
  logic              modeQ;
  logic              dutyLoad;
  logic [ACC_W-1:0]  triWave;
  logic [ACC_W-1:0]  carrier;
  logic [ACC_W:0]    dutyExt;
  logic              active;

  always_comb begin
    dutyLoad = evt.periodLoad || (evt.midCross && modeQ && midUpdate);
    triWave  = phase[ACC_W-1] ? {~phase[ACC_W-2:0], 1'b0} : {phase[ACC_W-2:0], 1'b0};
    carrier  = modeQ ? triWave : phase;
    dutyExt  = {dutyQ, {SHIFT{1'b0}}};
    active   = {1'b0, carrier} < dutyExt;
    pwmOut   = activeHigh ? active : !active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dutyQ <= '0;
      modeQ <= 1'b0;
    end else begin
      if (dutyLoad)       dutyQ <= duty;
      if (evt.periodLoad) modeQ <= symMode;
    end
  end

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!evt.periodLoad && !evt.midCross) |=> $stable(dutyQ));
  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !evt.periodLoad |=> $stable(modeQ));
  // R9
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (dutyQ == '0) |-> (pwmOut == !activeHigh));
endmodule

// File: rtl/pwm_carrier_gen.sv
module pwm_carrier_gen
  import pwm_carrier_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 10,
  parameter int DUTY_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync,
  input  logic [ACC_W-1:0]  freq,
  input  logic [PH_W-1:0]   initPhase,
  input  logic [DUTY_W-1:0] duty,
  input  logic              symMode,
  input  logic              midUpdate,
  input  logic              activeHigh,
  output logic              pwmOut,
  output logic              periodStrobe,
  output logic              midStrobe
);
  carrier_evt_t     evt;
  logic [ACC_W-1:0] phase;

  pwm_carrier_ctrl #(.ACC_W(ACC_W), .PH_W(PH_W), .PH_STEPS(1000)) u_ctrl (
    .clk(clk), .rst(rst), .sync(sync), .freq(freq), .initPhase(initPhase),
    .evt(evt), .phase(phase), .periodStrobe(periodStrobe), .midStrobe(midStrobe)
  );

  pwm_carrier_dp #(.ACC_W(ACC_W), .DUTY_W(DUTY_W)) u_dp (
    .clk(clk), .rst(rst), .evt(evt), .phase(phase), .duty(duty),
    .symMode(symMode), .midUpdate(midUpdate), .activeHigh(activeHigh),
    .pwmOut(pwmOut)
  );
endmodule

// File: tb/test_pwm_carrier_gen.sv
`timescale 1ns/1ps
module test_pwm_carrier_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync = 1'b0;
  logic [31:0] freq = 32'h0400_0000;
  logic [9:0]  initPhase = '0;
  logic [10:0] duty = '0;
  logic        symMode = 1'b0;
  logic        midUpdate = 1'b0;
  logic        activeHigh = 1'b1;
  logic        pwmOut, periodStrobe, midStrobe;

  always #5 clk = ~clk;

  pwm_carrier_gen i_pwm_carrier_gen (
    .clk(clk), .rst(rst), .sync(sync), .freq(freq), .initPhase(initPhase),
    .duty(duty), .symMode(symMode), .midUpdate(midUpdate), .activeHigh(activeHigh),
    .pwmOut(pwmOut), .periodStrobe(periodStrobe), .midStrobe(midStrobe)
  );

  typedef struct { logic pwm; logic ps; logic ms; string tag; } exp_t;
  exp_t expQ[$];
  int checks = 0, errors = 0;
  int highCnt = 0, psCnt = 0;

  // model state, written from the requirements
  logic [31:0] mAcc = '0;
  logic [10:0] mDuty = '0;
  logic        mMode = 1'b0;

  task automatic check(input string tag, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  function automatic logic modelPwm(input logic [31:0] acc, input logic [10:0] d,
                                    input logic m, input logic pol);
    logic [31:0] car;
    logic        act;
    car = acc;
    if (m) car = acc[31] ? {~acc[30:0], 1'b0} : {acc[30:0], 1'b0};
    act = {1'b0, car} < {d, 22'd0};
    return pol ? act : !act;
  endfunction

  // driver: called at a falling edge with inputs set; predicts and advances one clock
  task automatic tick(input string tag);
    logic [32:0] s;
    logic        pl, mc;
    logic [63:0] ld;
    logic [9:0]  ph;
    exp_t        e;
    s  = {1'b0, mAcc} + {1'b0, freq};
    pl = sync || s[32];
    mc = !sync && !mAcc[31] && s[31];
    ph = (initPhase > 10'd999) ? 10'd999 : initPhase;
    ld = 64'(ph) * 64'd4294967;
    if (pl || (mc && mMode && midUpdate)) mDuty = duty;
    if (pl) mMode = symMode;
    mAcc = sync ? ld[31:0] : s[31:0];
    e.pwm = modelPwm(mAcc, mDuty, mMode, activeHigh);
    e.ps = pl; e.ms = mc; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    highCnt += (pwmOut == activeHigh) ? 1 : 0;
    psCnt   += periodStrobe ? 1 : 0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic doSync(input logic [9:0] ip, input string tag);
    initPhase = ip; sync = 1'b1; tick(tag); sync = 1'b0;
  endtask

  // monitor: pops one expected item per predicted cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check(e.tag, pwmOut, e.pwm, "pwmOut");
        check(e.tag, periodStrobe, e.ps, "periodStrobe");
        check(e.tag, midStrobe, e.ms, "midStrobe");
      end
    end
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state: strobes low, duty 0 gives inactive output
    check("R11", periodStrobe, 1'b0, "periodStrobe after reset");
    check("R11", midStrobe, 1'b0, "midStrobe after reset");
    check("R11", pwmOut, 1'b0, "pwmOut after reset");

    // R4 sawtooth, R1 wrap and R2 mid strobes
    duty = 11'd256; symMode = 1'b0;
    doSync(10'd0, "R3");
    psCnt = 0;
    run(128, "R4");
    check("R1", psCnt == 2, 1'b1, "two period strobes in 128 cycles");

    // R7 duty change mid-period in sawtooth mode
    run(10, "R7"); duty = 11'd768; run(60, "R7"); duty = 11'd100; run(70, "R7");

    // R5 triangle, R6 mode change inside a period
    symMode = 1'b1; run(70, "R5");
    run(20, "R6"); symMode = 1'b0; run(50, "R6"); symMode = 1'b1; run(70, "R6");

    // R8 mid-period latch with and without the option
    duty = 11'd300; doSync(10'd0, "R8");
    midUpdate = 1'b1; run(10, "R8"); duty = 11'd800; run(64, "R8");
    midUpdate = 1'b0; run(10, "R8"); duty = 11'd200; run(64, "R8");
    midUpdate = 1'b1; symMode = 1'b0; run(64, "R8"); run(10, "R8"); duty = 11'd900; run(64, "R8");

    // R9 extremes
    duty = 11'd0; run(64, "R9"); highCnt = 0; run(64, "R9");
    check("R9", highCnt == 0, 1'b1, "zero duty never active");
    duty = 11'd1024; run(64, "R9"); highCnt = 0; run(64, "R9");
    check("R9", highCnt == 64, 1'b1, "full duty always active");
    symMode = 1'b1; duty = 11'd2047; run(64, "R9"); highCnt = 0; run(64, "R9");
    check("R9", highCnt == 64, 1'b1, "over-range duty always active");

    // R10 active-low
    activeHigh = 1'b0; duty = 11'd512; run(130, "R10"); activeHigh = 1'b1;

    // R3 sync with initial phase, including saturation
    run(7, "R3"); doSync(10'd500, "R3"); run(40, "R3");
    doSync(10'd1023, "R3"); run(40, "R3");
    freq = 32'h0123_4567; doSync(10'd250, "R1"); run(300, "R1");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule